// File: doc/BRIEF.md
# Configurable Output and Buried Macrocell Bank

This block is the row of storage and output cells that follows the OR plane of a programmable logic array. Every cell receives two sum terms from the array, a data term and an auxiliary term. Each cell's own two-bit configuration field decides what it does with them. It can pass the data term straight through, capture it in a flop clocked by the cell's own auxiliary term, or capture it in a flop clocked by the shared clock with the auxiliary term acting as a load enable. Both terms go through programmable polarity inversion before use. Pin cells have a data polarity bit and a per-cell output-enable term. Buried cells have no data polarity bit and instead offer their value in true and complemented form.

One active-high reset term is shared by all cells. It clears every flop to 0 at once, without waiting for any clock. The pad stage inverts the cell value, so a cleared pin cell drives a 1 whenever its enable is high. The cell value is also returned to the array from a point ahead of the pad inversion, whether or not the pad is enabled. As a result, a pin cell whose enable is held low still works as a buried cell.

Each cell has three behaviours, selected by its configuration field:
- COMB: transparent.
- TCLK: private-term clock.
- DECLK: shared clock with enable.

The fourth code, COMB_ALT, behaves as COMB. In DECLK a cell moves between a load transition and a hold transition on each shared clock edge. In TCLK a cell loads on each rising edge of its adjusted auxiliary term. The reset term forces both registered behaviours to the cleared state.

Top module: `pla_macrocell_bank`

## Requirements
- R1: Configuration code 2'b00 (cell i uses bits [2i+1:2i] of `cfg_mode`) makes the cell combinational: its value equals the adjusted data term at once, and neither the reset term nor the shared clock changes it.
- R2: Code 2'b10 makes the cell load the adjusted data term on a rising `clk` edge when the adjusted auxiliary term is 1. When that term is 0 the cell holds its value, and it never changes between edges except by reset.
- R3: Code 2'b01 makes the cell load the adjusted data term on each rising edge of the adjusted auxiliary term, independent of `clk`. A falling edge or a steady auxiliary term leaves the value unchanged.
- R4: The adjusted data term of pin cell i is `d_term[i] ^ cfg_dpol[i]`. The adjusted auxiliary term of any cell i is `e_term[i] ^ cfg_epol[i]`.
- R5: While `rst_term` is 1, every cell in code 2'b01 or 2'b10 reads 0 immediately, with no clock edge needed.
- R6: `pin_out[i]` is the inverse of pin cell i's value, so a cleared pin cell shows 1.
- R7: `pin_oe[i]` follows `oe_term[i]`. `fb_pin_cell[i]` carries the cell value whatever the enable is.
- R8: Buried cells (indices N_PIN and up) take `d_term` without a polarity bit. They drive `fb_bur_true` with their value and `fb_bur_comp` with its inverse.
- R9: Code 2'b11 behaves exactly as code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for cells in code 2'b10 |
| rst_term | input | 1 | Shared active-high asynchronous clear term |
| cfg_mode | input | 2*(N_PIN+N_BUR) | Per-cell behaviour code, two bits per cell |
| cfg_dpol | input | N_PIN | Data polarity bits, pin cells only |
| cfg_epol | input | N_PIN+N_BUR | Auxiliary term polarity bits |
| d_term | input | N_PIN+N_BUR | Data sum terms |
| e_term | input | N_PIN+N_BUR | Auxiliary sum terms |
| oe_term | input | N_PIN | Per-pin output-enable product terms |
| pin_out | output | N_PIN | Inverted pad drive value |
| pin_oe | output | N_PIN | Pad drive enable; 0 means high impedance |
| fb_pin_cell | output | N_PIN | Pin cell values fed back ahead of the pad |
| fb_bur_true | output | N_BUR | Buried cell values |
| fb_bur_comp | output | N_BUR | Complemented buried cell values |

## Verification
The bench builds the bank with N_PIN=4 and N_BUR=2. This keeps each vector short enough for expected values to be written out bit by bit. It still has several pin cells, so neighbours can sit in different codes at the same time, and it keeps both buried cells. With two buried cells, one can be registered while the other stays combinational. That reaches a buried cell loading through the shared-clock path next to a transparent one, and a private-term clocked cell ticking while the shared clock runs.

// File: rtl/mcell_pkg.sv
`timescale 1ns/1ps
package mcell_pkg;

    typedef enum logic [1:0] {
        MC_COMB     = 2'b00,
        MC_TCLK     = 2'b01,
        MC_DECLK    = 2'b10,
        MC_COMB_ALT = 2'b11
    } mc_mode_e;

    localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/mcell_core.sv
`timescale 1ns/1ps
module mcell_core
    import mcell_pkg::*;
(
    input  logic     clk,
    input  logic     rst_term,
    input  mc_mode_e mode,
    input  logic     dpol,
    input  logic     epol,
    input  logic     d_term,
    input  logic     e_term,
    output logic     q
);

    logic d_eff;
    logic e_eff;
    logic de_load;
    logic q_de;
    logic q_tc;

    // polarity stage
    assign d_eff   = d_term ^ dpol;
    assign e_eff   = e_term ^ epol;
    assign de_load = (mode == MC_DECLK) && e_eff;

    // shared clock register with load enable
    always_ff @(posedge clk or posedge rst_term) begin
        if (rst_term) begin
            q_de <= 1'b0;
        end else if (de_load) begin
            q_de <= d_eff;
        end
    end

    // register clocked by the cell's own adjusted auxiliary term
    always_ff @(posedge e_eff or posedge rst_term) begin
        if (rst_term) begin
            q_tc <= 1'b0;
        end else begin
            q_tc <= d_eff;
        end
    end

    // output selection by behaviour code
    always_comb begin
        unique case (mode)
            MC_TCLK:              q = q_tc;
            MC_DECLK:             q = q_de;
            MC_COMB, MC_COMB_ALT: q = d_eff;
            default:              q = d_eff;
        endcase
    end

    assert_de_load_R2: assert property (@(posedge clk) disable iff (rst_term)
        de_load |=> (q_de == $past(d_eff)));

    assert_de_hold_R2: assert property (@(posedge clk) disable iff (rst_term)
        !de_load |=> ((q_de == $past(q_de)) || (q_de == 1'b0)));

    assert_tclk_capture_R3: assert property (@(posedge e_eff) disable iff (rst_term)
        (mode == MC_TCLK) |=> (q_tc == $past(d_eff)));

    assert_reset_clear_R5: assert property (@(posedge clk)
        rst_term |-> ((q_de == 1'b0) && (q_tc == 1'b0)));

endmodule

// File: rtl/mcell_pad.sv
`timescale 1ns/1ps
module mcell_pad (
    input  logic cell_q,
    input  logic oe_term,
    output logic pad_o,
    output logic pad_oe
);

    // inverting tristate pad driver: value and enable to the pad ring
    assign pad_o  = ~cell_q;
    assign pad_oe = oe_term;

endmodule

// File: rtl/pla_macrocell_bank.sv
`timescale 1ns/1ps
module pla_macrocell_bank
    import mcell_pkg::*;
#(
    parameter int unsigned N_PIN = 10,
    parameter int unsigned N_BUR = 8
) (
    input  logic                            clk,
    input  logic                            rst_term,
    input  logic [MODE_W*(N_PIN+N_BUR)-1:0] cfg_mode,
    input  logic [N_PIN-1:0]                cfg_dpol,
    input  logic [N_PIN+N_BUR-1:0]          cfg_epol,
    input  logic [N_PIN+N_BUR-1:0]          d_term,
    input  logic [N_PIN+N_BUR-1:0]          e_term,
    input  logic [N_PIN-1:0]                oe_term,
    output logic [N_PIN-1:0]                pin_out,
    output logic [N_PIN-1:0]                pin_oe,
    output logic [N_PIN-1:0]                fb_pin_cell,
    output logic [N_BUR-1:0]                fb_bur_true,
    output logic [N_BUR-1:0]                fb_bur_comp
);

    localparam int unsigned N_CELL = N_PIN + N_BUR;

    logic [N_CELL-1:0] cell_q;

    for (genvar gi = 0; gi < N_PIN; gi++) begin : g_pin
        mcell_core u_core (
            .clk      (clk),
            .rst_term (rst_term),
            .mode     (mc_mode_e'(cfg_mode[MODE_W*gi +: MODE_W])),
            .dpol     (cfg_dpol[gi]),
            .epol     (cfg_epol[gi]),
            .d_term   (d_term[gi]),
            .e_term   (e_term[gi]),
            .q        (cell_q[gi])
        );

        mcell_pad u_pad (
            .cell_q  (cell_q[gi]),
            .oe_term (oe_term[gi]),
            .pad_o   (pin_out[gi]),
            .pad_oe  (pin_oe[gi])
        );

        assign fb_pin_cell[gi] = cell_q[gi];
    end

    for (genvar gb = 0; gb < N_BUR; gb++) begin : g_bur
        localparam int unsigned CI = N_PIN + gb;

        mcell_core u_core (
            .clk      (clk),
            .rst_term (rst_term),
            .mode     (mc_mode_e'(cfg_mode[MODE_W*CI +: MODE_W])),
            .dpol     (1'b0),
            .epol     (cfg_epol[CI]),
            .d_term   (d_term[CI]),
            .e_term   (e_term[CI]),
            .q        (cell_q[CI])
        );

        assign fb_bur_true[gb] = cell_q[CI];
        assign fb_bur_comp[gb] = ~cell_q[CI];
    end

endmodule

// File: tb/pla_macrocell_bank_tb.sv
`timescale 1ns/1ps
module pla_macrocell_bank_tb;

    localparam int NP = 4;
    localparam int NB = 2;
    localparam int NC = NP + NB;

    logic            clk = 1'b0;
    logic            rst_term;
    logic [2*NC-1:0] mode_r;
    logic [NP-1:0]   dpol_r;
    logic [NC-1:0]   epol_r;
    logic [NC-1:0]   d_r;
    logic [NC-1:0]   e_r;
    logic [NP-1:0]   oe_r;
    logic [NP-1:0]   pin_out;
    logic [NP-1:0]   pin_oe;
    logic [NP-1:0]   fb_pin_cell;
    logic [NB-1:0]   fb_bur_true;
    logic [NB-1:0]   fb_bur_comp;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    pla_macrocell_bank #(.N_PIN(NP), .N_BUR(NB)) u_dut (
        .clk         (clk),
        .rst_term    (rst_term),
        .cfg_mode    (mode_r),
        .cfg_dpol    (dpol_r),
        .cfg_epol    (epol_r),
        .d_term      (d_r),
        .e_term      (e_r),
        .oe_term     (oe_r),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .fb_pin_cell (fb_pin_cell),
        .fb_bur_true (fb_bur_true),
        .fb_bur_comp (fb_bur_comp)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic set_mode(input int idx, input logic [1:0] m);
        mode_r[2*idx +: 2] = m;
    endtask

    task automatic all_modes(input logic [1:0] m);
        for (int i = 0; i < NC; i++) set_mode(i, m);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R5 reset clears pin cells", fb_pin_cell, 4'h0);
        chk("R6 cleared cells show 1 at pads", pin_out, 4'hF);
        chk("R7 enable follows oe_term", pin_oe, 4'hF);
        chk("R8 buried true cleared", fb_bur_true, 2'b00);
        chk("R8 buried complement", fb_bur_comp, 2'b11);
        rst_term = 1'b0;
    endtask

    task automatic t_comb();
        @(negedge clk);
        all_modes(2'b00);
        d_r    = 6'b101101;
        dpol_r = 4'b0110;
        #1;
        chk("R1 R4 comb with data polarity", fb_pin_cell, 4'hB);
        chk("R6 comb pad inverted", pin_out, 4'h4);
        chk("R8 buried comb true", fb_bur_true, 2'b10);
        chk("R8 buried comb complement", fb_bur_comp, 2'b01);
        d_r    = 6'b010010;
        dpol_r = 4'b0011;
        #1;
        chk("R1 R4 comb second pattern", fb_pin_cell, 4'h1);
        rst_term = 1'b1;
        #1;
        chk("R1 reset has no effect in comb", fb_pin_cell, 4'h1);
        rst_term = 1'b0;
        @(posedge clk); #1;
        chk("R1 clock has no effect in comb", fb_pin_cell, 4'h1);
        set_mode(2, 2'b11);
        d_r[2]    = 1'b1;
        dpol_r[2] = 1'b0;
        #1;
        chk("R9 code 11 acts as comb", fb_pin_cell, 4'h5);
    endtask

    task automatic t_declk();
        @(negedge clk);
        all_modes(2'b10);
        d_r = '0; dpol_r = '0; epol_r = '0; e_r = '0;
        d_r[0] = 1'b1; e_r[0] = 1'b1;
        #1;
        chk("R2 no change before clock edge", fb_pin_cell[0], 1'b0);
        @(posedge clk); #1;
        chk("R2 load on enabled edge", fb_pin_cell[0], 1'b1);
        @(negedge clk);
        e_r[0] = 1'b0; d_r[0] = 1'b0;
        @(posedge clk); #1;
        chk("R2 hold when enable low", fb_pin_cell[0], 1'b1);
        @(negedge clk);
        epol_r[0] = 1'b1;
        @(posedge clk); #1;
        chk("R4 inverted enable loads", fb_pin_cell[0], 1'b0);
        @(negedge clk);
        dpol_r[0] = 1'b1;
        @(posedge clk); #1;
        chk("R4 inverted data loads one", fb_pin_cell[0], 1'b1);
        @(negedge clk);
        epol_r[0] = 1'b0; dpol_r[0] = 1'b0;
        @(posedge clk); #1;
        chk("R2 hold after enable drop", fb_pin_cell[0], 1'b1);
    endtask

    task automatic t_async_reset();
        @(posedge clk); #2;
        rst_term = 1'b1;
        #1;
        chk("R5 clear without clock edge", fb_pin_cell[0], 1'b0);
        chk("R6 cleared cell drives 1", pin_out[0], 1'b1);
        rst_term = 1'b0;
    endtask

    task automatic t_tclk();
        @(negedge clk);
        set_mode(1, 2'b01);
        d_r[1] = 1'b1; e_r[1] = 1'b0; epol_r[1] = 1'b0;
        #1;
        chk("R3 starts cleared", fb_pin_cell[1], 1'b0);
        repeat (3) @(posedge clk);
        #1;
        chk("R3 shared clock ignored", fb_pin_cell[1], 1'b0);
        #1; e_r[1] = 1'b1;
        #1;
        chk("R3 capture on term rise", fb_pin_cell[1], 1'b1);
        d_r[1] = 1'b0;
        #1;
        chk("R3 steady term holds", fb_pin_cell[1], 1'b1);
        e_r[1] = 1'b0;
        #1;
        chk("R3 falling edge ignored", fb_pin_cell[1], 1'b1);
        e_r[1] = 1'b1;
        #1;
        chk("R3 second rise captures zero", fb_pin_cell[1], 1'b0);
        set_mode(1, 2'b00);
        e_r[1] = 1'b0;
        #1; e_r[1] = 1'b1;
        #1; e_r[1] = 1'b0;
    endtask

    task automatic t_oe();
        @(negedge clk);
        all_modes(2'b00);
        d_r = 6'b000101; dpol_r = '0; oe_r = 4'b0011;
        #1;
        chk("R7 enable follows term", pin_oe, 4'h3);
        chk("R7 feedback ignores enable", fb_pin_cell, 4'h5);
        chk("R6 pad value inverted", pin_out, 4'hA);
    endtask

    task automatic t_buried();
        @(negedge clk);
        set_mode(4, 2'b10);
        set_mode(5, 2'b00);
        d_r[4] = 1'b1; e_r[4] = 1'b1; d_r[5] = 1'b1;
        #1;
        chk("R8 registered buried waits", fb_bur_true, 2'b10);
        @(posedge clk); #1;
        chk("R8 buried true after load", fb_bur_true, 2'b11);
        chk("R8 buried complement after load", fb_bur_comp, 2'b00);
    endtask

    initial begin
        rst_term = 1'b0;
        mode_r = '0; dpol_r = '0; epol_r = '0;
        d_r = '0; e_r = '0; oe_r = '1;
        all_modes(2'b10);
        #1 rst_term = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_comb();
        t_declk();
        t_async_reset();
        t_tclk();
        t_oe();
        t_buried();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule